// File: doc/BRIEF.md
# Mixed Edge/Level Prioritised Interrupt Controller

This block gathers active-low interrupt sources in banks of 32 lines and presents them to a processor as two request outputs: a normal request (IRQ) and a fast request (FIQ). Each line has its own configuration word. The word selects a 5-bit priority, falling-edge or low-level sensitivity, and which of the two outputs the line feeds. The controller records captured events in a pending register for each bank. It filters them through a mask register for each bank and runs a priority search across all banks for each output class.

Each output works as a one-shot handshake. It can rise only when its class is armed and an eligible line exists. When it rises, it consumes the arm flag and latches the winning line number. Software reads the latched number from a code register, and that read also clears the pending bit of an edge-sensitive winner. Software then writes a control bit to drop the output and re-arm the class. Level-sensitive lines cannot be cleared by software while their source is still driven low.

Access uses 32-bit words on a simple strobe interface. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are high. A read captures `bus_rdata` at the clock edge where `bus_sel` is high and `bus_wr` is low, so the data is valid in the following cycle. Byte address bits [9:8] select the bank and bits [7:0] select the register inside it. The code and control registers answer in every bank window that exists.

Top module: `lvint_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, every mask bit is 1, every configuration word reads 0, both code registers read 0, and `irq_o` and `fiq_o` are low with both classes armed.
- R2: The configuration word of line i of bank b sits at byte address b*256 + 0x1C + 4*i. Bits [6:2] hold the priority, bit 1 holds the sensitivity (0 = falling edge, 1 = low level), and bit 0 holds the steering (0 = IRQ, 1 = FIQ). A read returns those 7 bits with zeros above them.
- R3: An edge-sensitive line sets its pending bit (offset 0x00, bit i) only in the cycle after its input goes from 1 to 0. Holding the input low does not set the bit again once it has been cleared.
- R4: A level-sensitive line sets its pending bit in every cycle in which its input is low.
- R5: A write to offset 0x00 ANDs the pending register with the write data. A level-sensitive bit whose input is still low stays set.
- R6: Mask register at offset 0x04 is read/write. A mask bit of 1 keeps the line out of arbitration, while the line's pending bit is still captured.
- R7: Among eligible lines of a class, the lowest priority value wins. On equal priorities the highest line number wins, where bank b line i is line number 32*b + i.
- R8: An output rises one cycle after its class is armed and has an eligible line (pending, unmasked, steered to it). Rising clears the arm flag and latches the winner, and the output then stays high with that code until it is re-armed.
- R9: Writing offset 0x18 with bit 0 set (IRQ) or bit 1 set (FIQ) drives that output low at the write edge and re-arms the class. The class is evaluated again on the next edge.
- R10: A read of offset 0x10 returns the latched IRQ code, and a read of 0x14 returns the latched FIQ code. If the coded line is edge-sensitive, the read clears its pending bit. A level-sensitive pending bit is not touched.
- R11: A line steered to FIQ never causes `irq_o` to rise, and a line steered to IRQ never causes `fiq_o` to rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address: [9:8] bank, [7:0] register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| src_n | input | NBANKS*32 | Active-low interrupt sources, line 32*b+i at bit 32*b+i |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench targets the asymmetries between the two sensitivities. An edge line held low after a clear must stay clear, a level line must survive both a pending write and a code read, and a design that mixed these up would either re-raise edge events forever or lose a level request. The bench sets up a three-way contest whose pending lines are acknowledged one after another, so that a reversed tie-break or comparison shows up as a wrong code order. It also checks that the output drops on re-arm and comes back on the next edge while a source remains, which catches a design that forgets to re-evaluate or that never consumes the arm flag.

// File: rtl/lvint_pkg.sv
// Package: shared constants and types for the mixed edge/level controller.
// Assumes 32 lines per bank and a fixed per-line configuration layout.
package lvint_pkg;
    localparam int LINES_PER_BANK = 32;
    localparam int LINE_IDX_W     = 5;
    localparam int PRIO_W         = 5;
    localparam int CFG_W          = PRIO_W + 2;

    // Register offsets inside one bank window
    localparam logic [7:0] OFF_PEND     = 8'h00;
    localparam logic [7:0] OFF_MASK     = 8'h04;
    localparam logic [7:0] OFF_CODE_IRQ = 8'h10;
    localparam logic [7:0] OFF_CODE_FIQ = 8'h14;
    localparam logic [7:0] OFF_CTRL     = 8'h18;
    localparam logic [7:0] OFF_CFG0     = 8'h1C;

    // Per-line configuration word, bit order is software visible
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              to_fiq;
    } line_cfg_t;
endpackage

// File: rtl/lvint_bank.sv
// Module: one bank of 32 lines. Holds config words, mask and pending
// register, and captures falling edges or low levels per line.
// Assumes src_n is already synchronous to clk.
module lvint_bank
    import lvint_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LINES_PER_BANK-1:0]     src_n,
    input  logic                          cfg_wr,
    input  logic [LINE_IDX_W-1:0]         cfg_idx,
    input  logic [CFG_W-1:0]              cfg_wdata,
    input  logic                          mask_wr,
    input  logic                          pend_wr,
    input  logic [31:0]                   wdata,
    input  logic                          ack_en,
    input  logic [LINE_IDX_W-1:0]         ack_idx,
    output logic [LINES_PER_BANK-1:0]     pending_o,
    output logic [LINES_PER_BANK-1:0]     mask_o,
    output logic [LINES_PER_BANK-1:0]     steer_o,
    output logic [LINES_PER_BANK*PRIO_W-1:0] prio_o,
    output logic [LINES_PER_BANK*CFG_W-1:0]  cfg_o
);
    logic [LINES_PER_BANK-1:0] active;
    logic [LINES_PER_BANK-1:0] prev_q;
    logic [LINES_PER_BANK-1:0] pending_q;
    logic [LINES_PER_BANK-1:0] mask_q;
    logic [LINES_PER_BANK-1:0] lvl;
    logic [LINES_PER_BANK-1:0] set_v;
    logic [LINES_PER_BANK-1:0] keep_v;
    logic [LINES_PER_BANK-1:0] ack_v;

    assign active = ~src_n;

    // Per-line configuration registers
    for (genvar i = 0; i < LINES_PER_BANK; i++) begin : g_line
        line_cfg_t cfg_q;
        // Purpose: store the configuration word of line i
        always_ff @(posedge clk) begin
            if (!rst_n)
                cfg_q <= '0;
            else if (cfg_wr && cfg_idx == LINE_IDX_W'(i))
                cfg_q <= line_cfg_t'(cfg_wdata);
        end
        assign lvl[i]                      = cfg_q.level;
        assign steer_o[i]                  = cfg_q.to_fiq;
        assign prio_o[i*PRIO_W +: PRIO_W]  = cfg_q.prio;
        assign cfg_o[i*CFG_W +: CFG_W]     = cfg_q;
    end

    // Purpose: compute capture, software clear and acknowledge vectors
    always_comb begin
        set_v  = active & (lvl | ~prev_q);
        keep_v = pend_wr ? (wdata | (active & lvl)) : '1;
        ack_v  = '0;
        if (ack_en)
            ack_v[ack_idx] = ~lvl[ack_idx];
    end

    // Purpose: update the sampled inputs, pending and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= '0;
            pending_q <= '0;
            mask_q    <= '1;
        end else begin
            prev_q    <= active;
            pending_q <= (pending_q & keep_v & ~ack_v) | set_v;
            if (mask_wr)
                mask_q <= wdata;
        end
    end

    assign pending_o = pending_q;
    assign mask_o    = mask_q;

    // R3: an edge line becomes pending only after a 1-to-0 input transition
    a_r3_edge_needs_transition: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((pending_q & ~$past(pending_q) & ~$past(lvl)
                    & ~$past(active & ~prev_q)) == '0));

    // R5: a level line with a low input holds its pending bit
    a_r5_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|(active & lvl)) |=> (($past(active & lvl) & ~pending_q) == '0));
endmodule

// File: rtl/lvint_arbiter.sv
// Module: priority search over all lines of one class. Lowest priority
// value wins; on a tie the highest line number wins. Purely combinational.
module lvint_arbiter #(
    parameter int NLINES = 64,
    parameter int PW     = 5,
    localparam int IW    = $clog2(NLINES)
) (
    input  logic [NLINES-1:0]    elig_i,
    input  logic [NLINES*PW-1:0] prio_i,
    output logic                 valid_o,
    output logic [IW-1:0]        winner_o
);
    logic [PW-1:0] best;

    // Purpose: scan lines upward so a later equal priority replaces earlier
    always_comb begin
        valid_o  = 1'b0;
        winner_o = '0;
        best     = '1;
        for (int i = 0; i < NLINES; i++) begin
            if (elig_i[i] && (!valid_o || prio_i[i*PW +: PW] <= best)) begin
                valid_o  = 1'b1;
                best     = prio_i[i*PW +: PW];
                winner_o = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lvint_gate.sv
// Module: output handshake for one class. Raises the request when armed
// and a winner exists, then holds it and the latched code until re-armed.
module lvint_gate #(
    parameter int IW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [IW-1:0] winner_i,
    input  logic          rearm_i,
    output logic          out_o,
    output logic [IW-1:0] code_o
);
    logic armed_q;

    // Purpose: arm/fire state machine with winner latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            out_o   <= 1'b0;
            code_o  <= '0;
        end else if (rearm_i) begin
            armed_q <= 1'b1;
            out_o   <= 1'b0;
        end else if (armed_q && valid_i) begin
            armed_q <= 1'b0;
            out_o   <= 1'b1;
            code_o  <= winner_i;
        end
    end

    // R8: a rising request needs an armed class and an eligible line
    a_r8_rise_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_o) |-> $past(armed_q && valid_i));

    // R8: the latched code stays put while the request is held
    a_r8_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_o && $past(out_o)) |-> $stable(code_o));

    // R9: a re-arm write leaves the request low after that edge
    a_r9_rearm_drops: assert property (@(posedge clk) disable iff (!rst_n)
        rearm_i |=> !out_o);
endmodule

// File: rtl/lvint_ctrl.sv
// Module: top of the mixed edge/level interrupt controller. Decodes the
// word bus, instantiates the banks, one arbiter and one gate per class,
// and registers read data. Assumes word-aligned 32-bit accesses.
module lvint_ctrl
    import lvint_pkg::*;
#(
    parameter int NBANKS = 2,
    localparam int NLINES = NBANKS * LINES_PER_BANK,
    localparam int CODE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [9:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] src_n,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [1:0]            bank_sel;
    logic [7:0]            off;
    logic [7:0]            cfg_off;
    logic                  bank_ok;
    logic                  is_cfg;
    logic                  wr;
    logic                  rd;
    int                    bidx;
    logic [LINE_IDX_W-1:0] cfg_idx;

    logic [NLINES-1:0]        pend_all;
    logic [NLINES-1:0]        mask_all;
    logic [NLINES-1:0]        steer_all;
    logic [NLINES*PRIO_W-1:0] prio_all;
    logic [NLINES*CFG_W-1:0]  cfg_all;

    logic [NLINES-1:0] elig   [2];
    logic              valid  [2];
    logic [CODE_W-1:0] winner [2];
    logic              rearm  [2];
    logic              out_v  [2];
    logic [CODE_W-1:0] code   [2];

    logic irq_ack;
    logic fiq_ack;
    logic [CODE_W-1:0] ack_code;

    // Purpose: address decode shared by reads and writes
    always_comb begin
        bank_sel = bus_addr[9:8];
        off      = bus_addr[7:0];
        cfg_off  = off - OFF_CFG0;
        bank_ok  = int'(bank_sel) < NBANKS;
        bidx     = bank_ok ? int'(bank_sel) : 0;
        is_cfg   = (off >= OFF_CFG0) && !cfg_off[7] && (cfg_off[1:0] == 2'b00);
        cfg_idx  = cfg_off[6:2];
        wr       = bus_sel && bus_wr && bank_ok;
        rd       = bus_sel && !bus_wr && bank_ok;
        irq_ack  = rd && off == OFF_CODE_IRQ;
        fiq_ack  = rd && off == OFF_CODE_FIQ;
        ack_code = fiq_ack ? code[1] : code[0];
    end

    // One bank per 32 lines
    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        lvint_bank u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_n     (src_n[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .cfg_wr    (wr && is_cfg && bidx == b),
            .cfg_idx   (cfg_idx),
            .cfg_wdata (bus_wdata[CFG_W-1:0]),
            .mask_wr   (wr && off == OFF_MASK && bidx == b),
            .pend_wr   (wr && off == OFF_PEND && bidx == b),
            .wdata     (bus_wdata),
            .ack_en    ((irq_ack || fiq_ack) &&
                        (ack_code >> LINE_IDX_W) == CODE_W'(b)),
            .ack_idx   (ack_code[LINE_IDX_W-1:0]),
            .pending_o (pend_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .mask_o    (mask_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .steer_o   (steer_all[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .prio_o    (prio_all[b*LINES_PER_BANK*PRIO_W +: LINES_PER_BANK*PRIO_W]),
            .cfg_o     (cfg_all[b*LINES_PER_BANK*CFG_W +: LINES_PER_BANK*CFG_W])
        );
    end

    assign elig[0] = pend_all & ~mask_all & ~steer_all;
    assign elig[1] = pend_all & ~mask_all &  steer_all;

    // Class 0 = IRQ, class 1 = FIQ
    for (genvar c = 0; c < 2; c++) begin : g_class
        assign rearm[c] = wr && off == OFF_CTRL && bus_wdata[c];

        lvint_arbiter #(.NLINES(NLINES), .PW(PRIO_W)) u_arb (
            .elig_i   (elig[c]),
            .prio_i   (prio_all),
            .valid_o  (valid[c]),
            .winner_o (winner[c])
        );

        lvint_gate #(.IW(CODE_W)) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .valid_i  (valid[c]),
            .winner_i (winner[c]),
            .rearm_i  (rearm[c]),
            .out_o    (out_v[c]),
            .code_o   (code[c])
        );
    end

    assign irq_o = out_v[0];
    assign fiq_o = out_v[1];

    // Purpose: registered read data mux
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd) begin
            if (is_cfg)
                bus_rdata <= 32'(cfg_all[(bidx*LINES_PER_BANK + int'(cfg_idx))*CFG_W +: CFG_W]);
            else begin
                case (off)
                    OFF_PEND:     bus_rdata <= pend_all[bidx*LINES_PER_BANK +: LINES_PER_BANK];
                    OFF_MASK:     bus_rdata <= mask_all[bidx*LINES_PER_BANK +: LINES_PER_BANK];
                    OFF_CODE_IRQ: bus_rdata <= 32'(code[0]);
                    OFF_CODE_FIQ: bus_rdata <= 32'(code[1]);
                    default:      bus_rdata <= '0;
                endcase
            end
        end
    end

    // R11: an IRQ request rises only with an IRQ-steered eligible line
    a_r11_irq_steered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|elig[0]));

    // R11: a FIQ request rises only with a FIQ-steered eligible line
    a_r11_fiq_steered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_o) |-> $past(|elig[1]));

    // R6: a fully masked controller never raises a request
    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_all) |=> !$rose(irq_o) && !$rose(fiq_o));
endmodule

// File: tb/lvint_ctrl_test.sv
module lvint_ctrl_test;
    localparam int NB = 2;
    localparam int NL = NB * 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [9:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] src_n = '1;
    logic          irq_o;
    logic          fiq_o;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    lvint_ctrl #(.NBANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_n(src_n), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    function automatic logic [9:0] cfg_addr(int b, int i);
        return 10'(b*256 + 'h1C + 4*i);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [9:0] a, logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [9:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cleanup();
        src_n = '1;
        idle(1);
        bus_write(10'h004, '1);
        bus_write(10'h104, '1);
        bus_write(10'h000, '0);
        bus_write(10'h100, '0);
        bus_write(10'h018, 32'h3);
        idle(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq_o", 32'(irq_o), 0);
        check("R1 fiq_o", 32'(fiq_o), 0);
        bus_read(10'h000, d); check("R1 pending", d, 0);
        bus_read(10'h004, d); check("R1 mask b0", d, 32'hFFFF_FFFF);
        bus_read(10'h104, d); check("R1 mask b1", d, 32'hFFFF_FFFF);
        bus_read(cfg_addr(0, 5), d); check("R1 cfg", d, 0);
        bus_read(10'h010, d); check("R1 irq code", d, 0);
        bus_read(10'h014, d); check("R1 fiq code", d, 0);
    endtask

    task automatic t_config();
        logic [31:0] d;
        bus_write(cfg_addr(0, 3), 32'h47);
        bus_read(cfg_addr(0, 3), d); check("R2 cfg b0 l3", d, 32'h47);
        bus_write(cfg_addr(1, 31), 32'hFFFF_FF7F);
        bus_read(cfg_addr(1, 31), d); check("R2 cfg b1 l31", d, 32'h7F);
        bus_write(cfg_addr(0, 3), 0);
        bus_write(cfg_addr(1, 31), 0);
        bus_read(cfg_addr(1, 31), d); check("R2 cfg cleared", d, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        src_n[2] = 1'b0; idle(2);
        bus_read(10'h000, d); check("R3 edge sets", d, 32'h4);
        bus_write(10'h000, 0);
        bus_read(10'h000, d); check("R3 clear while low", d, 0);
        idle(3);
        bus_read(10'h000, d); check("R3 no re-set while held", d, 0);
        src_n[2] = 1'b1; idle(1); src_n[2] = 1'b0; idle(2);
        bus_read(10'h000, d); check("R3 second edge", d, 32'h4);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        bus_write(cfg_addr(0, 4), 32'h2);
        src_n[4] = 1'b0; idle(2);
        bus_read(10'h000, d); check("R4 level sets", d, 32'h10);
        bus_write(10'h000, 0);
        bus_read(10'h000, d); check("R5 level clear refused", d, 32'h10);
        src_n[6] = 1'b0; idle(2);
        bus_read(10'h000, d); check("R5 two pending", d, 32'h50);
        bus_write(10'h000, 32'h40);
        bus_read(10'h000, d); check("R5 AND keeps", d, 32'h50);
        bus_write(10'h000, 0);
        bus_read(10'h000, d); check("R5 AND clears edge", d, 32'h10);
        src_n[4] = 1'b1; idle(1);
        bus_write(10'h000, 0);
        bus_read(10'h000, d); check("R5 released clears", d, 0);
        bus_write(cfg_addr(0, 4), 0);
        cleanup();
    endtask

    task automatic t_output();
        logic [31:0] d;
        src_n[6] = 1'b0; idle(3);
        check("R6 masked no irq", 32'(irq_o), 0);
        bus_read(10'h000, d); check("R6 captured while masked", d, 32'h40);
        bus_write(10'h004, ~32'h40); idle(2);
        check("R8 irq rises", 32'(irq_o), 1);
        check("R11 irq line not on fiq", 32'(fiq_o), 0);
        bus_read(10'h010, d); check("R10 irq code", d, 6);
        bus_read(10'h000, d); check("R10 edge acked", d, 0);
        check("R8 irq held", 32'(irq_o), 1);
        bus_write(10'h018, 32'h1);
        check("R9 rearm drops", 32'(irq_o), 0);
        idle(3);
        check("R9 stays low, none pending", 32'(irq_o), 0);
        cleanup();
    endtask

    task automatic t_level_ack();
        logic [31:0] d;
        bus_write(cfg_addr(0, 4), 32'h2);
        bus_write(10'h004, ~32'h10);
        src_n[4] = 1'b0; idle(3);
        check("R8 level irq", 32'(irq_o), 1);
        bus_read(10'h010, d); check("R10 level code", d, 4);
        bus_read(10'h000, d); check("R10 level not acked", d, 32'h10);
        bus_write(10'h018, 32'h1);
        check("R9 drop at rearm", 32'(irq_o), 0);
        idle(1);
        check("R9 re-evaluated", 32'(irq_o), 1);
        src_n[4] = 1'b1;
        bus_write(cfg_addr(0, 4), 0);
        cleanup();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        bus_write(cfg_addr(0, 1), 32'h08);
        bus_write(cfg_addr(0, 9), 32'h0C);
        bus_write(cfg_addr(1, 0), 32'h0C);
        src_n[1] = 1'b0; src_n[9] = 1'b0; src_n[32] = 1'b0; idle(2);
        bus_write(10'h104, ~32'h1);
        bus_write(10'h004, ~32'h202);
        bus_write(10'h018, 32'h1); idle(2);
        bus_read(10'h010, d); check("R7 lowest value wins", d, 1);
        bus_write(10'h018, 32'h1); idle(2);
        bus_read(10'h010, d); check("R7 tie to highest line", d, 32);
        bus_write(10'h018, 32'h1); idle(2);
        bus_read(10'h010, d); check("R7 last remaining", d, 9);
        bus_write(cfg_addr(0, 1), 0);
        bus_write(cfg_addr(0, 9), 0);
        bus_write(cfg_addr(1, 0), 0);
        cleanup();
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        bus_write(cfg_addr(0, 7), 32'h1);
        bus_write(10'h004, ~32'h80);
        src_n[7] = 1'b0; idle(3);
        check("R11 fiq rises", 32'(fiq_o), 1);
        check("R11 irq quiet", 32'(irq_o), 0);
        bus_read(10'h014, d); check("R10 fiq code", d, 7);
        bus_write(10'h018, 32'h2);
        check("R9 fiq rearm drops", 32'(fiq_o), 0);
        bus_write(cfg_addr(0, 7), 0);
        cleanup();
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_config();
        t_edge();
        t_level();
        t_output();
        t_level_ack();
        t_prio();
        t_fiq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule